// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block sits in the address path in front of a two-channel interleaved memory. Tiled graphics surfaces and the CPU pick the memory channel from different address bits. To make both sides address the same bytes, bit 6 of a byte address is rewritten as an XOR with a few higher address bits.

Which higher bits take part depends on two things. The first is the tiling orientation of the access: linear, X-tiled or Y-tiled. The second is the static memory configuration: the channel addressing mode, a flag that turns off CPU channel randomisation, a select that picks bit 11 or bit 17 as the randomisation bit, and whether both channels hold equal capacity.

For each access strobe, the block registers four results one clock later: the rewritten address, the swizzle mode that was applied, the mode as software should see it, and the effective tiling.

The configuration input is treated as a word made of the channel mode, the disable flag, the select and the capacity flag. When every bit of that word is one, the configuration is taken as unreadable. Every tiled access is then reported as linear.

Top module: `tile_chan_swizzler`

## Requirements
- R1: When the configuration is interleaved (channel code 2), the capacities are equal and randomisation is off (`cfg_xor_off`=1), an X-tiled access (tile code 1) gets bit 6 replaced by bit6^bit9^bit10, and `out_mode` is 2.
- R2: Under the same configuration, a Y-tiled access (tile code 2) gets bit 6 replaced by bit6^bit9, and `out_mode` is 1.
- R3: When the configuration is interleaved with equal capacities, `cfg_xor_off`=0 and `cfg_xor_hi`=0, bit 11 is also XORed into bit 6. `out_mode` is 4 for X-tiled and 3 for Y-tiled.
- R4: With the same configuration but `cfg_xor_hi`=1, bit 17 is XORed in instead of bit 11. `out_mode` is 6 for X-tiled and 5 for Y-tiled.
- R5: The address passes unchanged and `out_mode` is 0 in each of these cases: linear access (tile code 0), reserved tile code 3, single-channel memory (channel code 0), asymmetric memory (channel code 1), or channel code 3 when the configuration is not all ones.
- R6: When `cfg_cap_eq`=0, `out_mode` is 0 for every tiling and the address is unchanged.
- R7: When the configuration word is all ones (channel code 3 and all three flags 1), a tiled access gives `out_mode`=7 (unknown), `out_sw_mode`=0, `out_tile`=0, and the address is unchanged.
- R8: `out_sw_mode` equals `out_mode`, with three exceptions: 5 is reported as 1, 6 is reported as 2, and 7 is reported as 0.
- R9: Every output address bit other than bit 6 equals the corresponding bit of the input address.
- R10: `out_valid` equals `in_valid` one clock later. The other outputs update only on a cycle with `in_valid` high and otherwise hold their values.
- R11: Synchronous reset clears every output to zero.
- R12: `out_tile` reports the effective tiling. It is the input tile code for X (1) or Y (2), except that an unknown configuration gives 0. Tile codes 0 and 3 report 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Access strobe |
| in_addr | input | ADDR_W | Byte address |
| in_tile | input | 2 | Tiling: 0 linear, 1 X, 2 Y, 3 reserved |
| cfg_chan | input | 2 | Channel mode: 0 single, 1 asymmetric, 2 interleaved, 3 reserved |
| cfg_xor_off | input | 1 | CPU channel randomisation disabled |
| cfg_xor_hi | input | 1 | Randomisation bit select: 0 bit 11, 1 bit 17 |
| cfg_cap_eq | input | 1 | Both channels hold equal capacity |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_addr | output | ADDR_W | Swizzled address |
| out_tile | output | 2 | Effective tiling |
| out_mode | output | 3 | Applied swizzle mode code |
| out_sw_mode | output | 3 | Mode as reported to software |

## Verification
The bench walks through every combination of orientation and configuration, using addresses whose bits 9, 10, 11 and 17 are set in different patterns. A wrong XOR term then changes bit 6 and shows up in the compare.

It drives the all-ones configuration next to channel code 3 with one flag cleared. A design that decodes only the channel mode would report unknown, or would fail to report it, in one of those two cases.

It also checks the folding of the bit-17 modes and the hold behaviour on idle cycles. A design that folded the physical mode instead of the reported one, or that reloaded its outputs while the strobe was low, would differ from the behavioural model on the first cycle it matters.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE      = 3'd0,
    SWZ_B9        = 3'd1,
    SWZ_B9_10     = 3'd2,
    SWZ_B9_11     = 3'd3,
    SWZ_B9_10_11  = 3'd4,
    SWZ_B9_17     = 3'd5,
    SWZ_B9_10_17  = 3'd6,
    SWZ_UNKNOWN   = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    CH_SINGLE      = 2'd0,
    CH_ASYM        = 2'd1,
    CH_INTERLEAVED = 2'd2,
    CH_RSVD        = 2'd3
  } chan_e;

  typedef struct packed {
    chan_e chan;
    logic  xor_off;
    logic  xor_hi;
    logic  cap_eq;
  } mem_cfg_t;

  // Address bit positions fixed by the channel-select hardware
  localparam int unsigned BIT_DST  = 6;
  localparam int unsigned BIT_R9   = 9;
  localparam int unsigned BIT_R10  = 10;
  localparam int unsigned BIT_LO   = 11;
  localparam int unsigned BIT_HI   = 17;
  localparam int unsigned MIN_ADDR = BIT_HI + 1;

endpackage

// File: rtl/swz_mode_sel.sv
// Chooses the X and Y swizzle modes from the static memory configuration.
module swz_mode_sel
  import swz_pkg::*;
(
  input  mem_cfg_t  cfg,
  output swz_mode_e x_mode,
  output swz_mode_e y_mode
);

  logic cfg_fail;

  always_comb begin
    cfg_fail = &cfg;
    x_mode   = SWZ_NONE;
    y_mode   = SWZ_NONE;
    if (cfg_fail) begin
      x_mode = SWZ_UNKNOWN;
      y_mode = SWZ_UNKNOWN;
    end else if (cfg.cap_eq && cfg.chan == CH_INTERLEAVED) begin
      if (cfg.xor_off) begin
        x_mode = SWZ_B9_10;
        y_mode = SWZ_B9;
      end else if (!cfg.xor_hi) begin
        x_mode = SWZ_B9_10_11;
        y_mode = SWZ_B9_11;
      end else begin
        x_mode = SWZ_B9_10_17;
        y_mode = SWZ_B9_17;
      end
    end
  end

endmodule

// File: rtl/swz_tile_pick.sv
// Picks the mode for one access and derives the software view.
module swz_tile_pick
  import swz_pkg::*;
(
  input  tile_e     tile,
  input  swz_mode_e x_mode,
  input  swz_mode_e y_mode,
  output swz_mode_e mode,
  output swz_mode_e sw_mode,
  output tile_e     eff_tile
);

  always_comb begin
    unique case (tile)
      TILE_X:  mode = x_mode;
      TILE_Y:  mode = y_mode;
      default: mode = SWZ_NONE;
    endcase

    if (mode == SWZ_UNKNOWN || (tile != TILE_X && tile != TILE_Y))
      eff_tile = TILE_LINEAR;
    else
      eff_tile = tile;

    unique case (mode)
      SWZ_B9_17:    sw_mode = SWZ_B9;
      SWZ_B9_10_17: sw_mode = SWZ_B9_10;
      SWZ_UNKNOWN:  sw_mode = SWZ_NONE;
      default:      sw_mode = mode;
    endcase
  end

endmodule

// File: rtl/swz_bit6_xor.sv
// Rewrites bit 6 from the higher bits that the mode selects.
module swz_bit6_xor
  import swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_mode_e         mode,
  output logic [ADDR_W-1:0] addr_o
);

  logic use_r9, use_r10, use_lo, use_hi, flip;

  always_comb begin
    use_r9  = (mode != SWZ_NONE) && (mode != SWZ_UNKNOWN);
    use_r10 = (mode == SWZ_B9_10) || (mode == SWZ_B9_10_11) ||
              (mode == SWZ_B9_10_17);
    use_lo  = (mode == SWZ_B9_11) || (mode == SWZ_B9_10_11);
    use_hi  = (mode == SWZ_B9_17) || (mode == SWZ_B9_10_17);
    flip    = (use_r9  & addr_i[BIT_R9])  ^ (use_r10 & addr_i[BIT_R10]) ^
              (use_lo  & addr_i[BIT_LO])  ^ (use_hi  & addr_i[BIT_HI]);
    addr_o          = addr_i;
    addr_o[BIT_DST] = addr_i[BIT_DST] ^ flip;
  end

endmodule

// File: rtl/tile_chan_swizzler.sv
module tile_chan_swizzler
  import swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tile,
  input  logic [1:0]        cfg_chan,
  input  logic              cfg_xor_off,
  input  logic              cfg_xor_hi,
  input  logic              cfg_cap_eq,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_tile,
  output logic [2:0]        out_mode,
  output logic [2:0]        out_sw_mode
);

  mem_cfg_t          cfg;
  swz_mode_e         x_mode, y_mode, mode, sw_mode;
  tile_e             eff_tile;
  logic [ADDR_W-1:0] addr_swz;

  assign cfg = {cfg_chan, cfg_xor_off, cfg_xor_hi, cfg_cap_eq};

  swz_mode_sel u_sel (
    .cfg    (cfg),
    .x_mode (x_mode),
    .y_mode (y_mode)
  );

  swz_tile_pick u_pick (
    .tile     (tile_e'(in_tile)),
    .x_mode   (x_mode),
    .y_mode   (y_mode),
    .mode     (mode),
    .sw_mode  (sw_mode),
    .eff_tile (eff_tile)
  );

  swz_bit6_xor #(.ADDR_W(ADDR_W)) u_xor (
    .addr_i (in_addr),
    .mode   (mode),
    .addr_o (addr_swz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_tile    <= '0;
      out_mode    <= '0;
      out_sw_mode <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr    <= addr_swz;
        out_tile    <= eff_tile;
        out_mode    <= mode;
        out_sw_mode <= sw_mode;
      end
    end
  end

endmodule

// File: rtl/swz_chk.sv
module swz_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_tile,
  input logic [1:0]        cfg_chan,
  input logic              cfg_xor_off,
  input logic              cfg_xor_hi,
  input logic              cfg_cap_eq,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_tile,
  input logic [2:0]        out_mode,
  input logic [2:0]        out_sw_mode
);

  localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << 6);

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_mode)));

  assert_upper_bits_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_addr & KEEP) == ($past(in_addr) & KEEP)));

  assert_linear_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_tile == 2'd0) |=>
      (out_addr == $past(in_addr) && out_mode == 3'd0));

  assert_unequal_none_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_cap_eq) |=> (out_mode == 3'd0));

  assert_sw_folded_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sw_mode < 3'd5));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && out_addr == '0 && out_mode == 3'd0));

endmodule

bind tile_chan_swizzler swz_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tile_chan_swizzler_bench.sv
module tile_chan_swizzler_bench;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0]        in_tile = '0;
  logic [1:0]        cfg_chan = '0;
  logic              cfg_xor_off = 1'b0, cfg_xor_hi = 1'b0, cfg_cap_eq = 1'b0;
  logic              out_valid;
  logic [ADDR_W-1:0] out_addr;
  logic [1:0]        out_tile;
  logic [2:0]        out_mode, out_sw_mode;

  int tests = 0, fails = 0;

  tile_chan_swizzler #(.ADDR_W(ADDR_W)) u_tile_chan_swizzler (.*);

  always #4 clk = ~clk;

  // expected state of the registered outputs
  logic [ADDR_W-1:0] e_addr = '0;
  int e_mode = 0, e_sw = 0, e_tile = 0, e_valid = 0;
  string e_tag = "R11";
  logic [ADDR_W-1:0] e_in_addr = '0;

  task automatic check(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int t, int cm, bit xo, bit xh, bit ce);
    if (cm == 3 && xo && xh && ce && (t == 1 || t == 2)) return "R7";
    if (t != 1 && t != 2) return "R5";
    if (!ce) return "R6";
    if (cm != 2) return "R5";
    if (xo) return (t == 1) ? "R1" : "R2";
    if (!xh) return "R3";
    return "R4";
  endfunction

  // behavioural model of one access
  task automatic model(input logic [ADDR_W-1:0] a, input int t, input int cm,
                       input bit xo, input bit xh, input bit ce);
    bit bad = (cm == 3) && xo && xh && ce;
    bit tiled = (t == 1 || t == 2);
    bit f;
    int m;
    if (!tiled) m = 0;
    else if (bad) m = 7;
    else if (!ce || cm != 2) m = 0;
    else if (xo) m = (t == 1) ? 2 : 1;
    else if (!xh) m = (t == 1) ? 4 : 3;
    else m = (t == 1) ? 6 : 5;
    case (m)
      1: f = a[9];
      2: f = a[9] ^ a[10];
      3: f = a[9] ^ a[11];
      4: f = a[9] ^ a[10] ^ a[11];
      5: f = a[9] ^ a[17];
      6: f = a[9] ^ a[10] ^ a[17];
      default: f = 1'b0;
    endcase
    e_addr = a;
    e_addr[6] = a[6] ^ f;
    e_mode = m;
    e_sw = (m == 5) ? 1 : (m == 6) ? 2 : (m == 7) ? 0 : m;
    e_tile = (tiled && m != 7) ? t : 0;
    e_in_addr = a;
    e_tag = tag_of(t, cm, xo, xh, ce);
  endtask

  bit p_rst = 1'b1, p_valid = 1'b0;
  logic [ADDR_W-1:0] p_addr = '0;
  int p_t = 0, p_cm = 0;
  bit p_xo = 0, p_xh = 0, p_ce = 0;

  // one cycle: check what the last posedge produced, then drive new inputs
  task automatic step(bit r, bit v, logic [ADDR_W-1:0] a, int t, int cm,
                      bit xo, bit xh, bit ce);
    @(negedge clk);
    if (p_rst) begin
      e_addr = '0; e_mode = 0; e_sw = 0; e_tile = 0; e_valid = 0;
      check("R11", "reset addr", out_addr, 0);
      check("R11", "reset valid", out_valid, 0);
      check("R11", "reset mode", {out_tile, out_mode, out_sw_mode}, 0);
    end else begin
      e_valid = p_valid;
      check("R10", "valid", out_valid, e_valid);
      if (p_valid) begin
        model(p_addr, p_t, p_cm, p_xo, p_xh, p_ce);
        check(e_tag, "addr", out_addr, e_addr);
        check("R9", "upper bits", out_addr & ~32'h40, e_in_addr & ~32'h40);
        check(e_tag, "mode", out_mode, e_mode);
        check("R8", "sw mode", out_sw_mode, e_sw);
        check("R12", "tile", out_tile, e_tile);
      end else begin
        check("R10", "hold addr", out_addr, e_addr);
        check("R10", "hold mode", {out_tile, out_mode, out_sw_mode},
              {e_tile[1:0], e_mode[2:0], e_sw[2:0]});
      end
    end
    rst = r; in_valid = v; in_addr = a; in_tile = t[1:0];
    cfg_chan = cm[1:0]; cfg_xor_off = xo; cfg_xor_hi = xh; cfg_cap_eq = ce;
    p_rst = r; p_valid = v; p_addr = a; p_t = t; p_cm = cm;
    p_xo = xo; p_xh = xh; p_ce = ce;
  endtask

  localparam logic [31:0] PAT [6] = '{32'h0000_0200, 32'h0000_0600,
    32'h0000_0A40, 32'h0002_0000, 32'h0002_0E40, 32'hFFFF_FFFF};

  initial begin
    step(1, 1, 32'hFFFF_FFFF, 1, 2, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // every orientation and configuration against patterned addresses
    for (int p = 0; p < 6; p++)
      for (int cm = 0; cm < 4; cm++)
        for (int fl = 0; fl < 8; fl++)
          for (int t = 0; t < 4; t++)
            step(0, 1, PAT[p], t, cm, fl[2], fl[1], fl[0]);
    // idle cycles must hold results
    step(0, 1, 32'h0002_0640, 1, 2, 0, 1, 1);
    step(0, 0, 32'h1234_5678, 2, 3, 1, 1, 1);
    step(0, 0, 32'h0, 0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom;
      step(0, (r & 3) != 0, $urandom, (r >> 2) & 3, (r >> 4) & 3,
           r[6], r[7], r[8] | r[9]);
    end
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule